// File: doc/BRIEF.md
# Serial register front end for a real-time clock

This block lets an SPI master reach the register file of a real-time clock. Every chip-select period opens with one address byte. Its top bit selects the direction, with 1 for a write and 0 for a read. Its low seven bits give the starting register. Each later byte in the same period reaches the next register up, so one period can carry a burst. The SPI pins are synchronized into the system clock. SCLK edges are detected in that domain, so the system clock must run at least six times faster than SCLK. At 250 MHz this leaves a wide margin over a 2 MHz serial clock.

The block keeps some registers itself and forwards the rest to neighbouring units.

- **Held locally:** the control register, the charger-configuration byte and a 96-byte scratch RAM.
- **Forwarded:** the time, alarm and status registers live in the timekeeping and alarm units. The block passes those accesses out as single-cycle strobes on a parallel bus. A neighbour can then treat a read as a side effect, for example clearing an alarm flag.

SPI cannot pause the serial clock, so the bus has no back-pressure. A neighbour must return read data combinationally in the cycle of its read strobe, and must accept a write strobe in the cycle it appears. The write-protect bit is a control-register bit, and it blocks every write except writes to the control register itself.

Top module: `rtc_spi_if`

## Requirements
- R1: The first byte after chip select rises is the address byte. Bit 7 = 1 makes the period a write and bit 7 = 0 a read. Bits 6:0 are the starting register address.
- R2: Each later byte in the same period goes to the next address up. The address wraps from 0x7F to 0x00.
- R3: Chip select is active high and SCLK idles low. MOSI is sampled on SCLK falling edges. MISO changes on SCLK rising edges, so the first read bit appears on the first rising edge of the byte. MISO is high-impedance whenever chip select is low.
- R4: When control bit 6 (write protect) is 1, writes to every address except 0x0F are dropped. No write strobe is issued, and the local registers and RAM keep their contents.
- R5: Register 0x0F is the control register. It reads back with bits 5:3 forced to 0 and drives ctrl_q.
- R6: Reads of the status register at 0x10 come from ext_rdata with bits 7:2 forced to 0.
- R7: Register 0x11 is a plain read/write byte, shown on trickle_q.
- R8: Addresses 0x20 to 0x7F are a 96-byte read/write scratch RAM.
- R9: Addresses 0x12 to 0x1F read as 0x00, and writes to them have no effect and issue no strobe.
- R10: Each byte read from 0x00 to 0x0E or from 0x10 raises ext_rd for exactly one cycle with ext_addr set, and the byte is taken from ext_rdata in that cycle. Each permitted byte written there raises ext_wr for one cycle with ext_addr and ext_wdata. ext_rd and ext_wr are never high together.
- R11: Dropping chip select in the middle of a byte discards the partial byte. The next period starts again with an address byte.
- R12: After reset, ctrl_q equals CTRL_RST (default 0x00), trickle_q is 0x00, and MISO is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, high-impedance when deselected |
| ext_rd | output | 1 | Read strobe for a forwarded register |
| ext_wr | output | 1 | Write strobe for a forwarded register |
| ext_addr | output | 7 | Address of the forwarded access |
| ext_wdata | output | 8 | Write data of the forwarded access |
| ext_rdata | input | 8 | Read data from neighbour, valid in the ext_rd cycle |
| ctrl_q | output | 8 | Current control register |
| trickle_q | output | 8 | Current charger-configuration byte |

## Verification
A corrupted address counter shows up within one byte. The next burst byte is then read back from, or written to, the wrong location, and for forwarded addresses ext_addr is wrong at once. A bit counter that drifts, or a direction flag that is stale, skews every following byte of the period and leaves the next period unaffected. A wrong protect state shows as a missing or extra ext_wr pulse, or as a changed trickle_q, on the cycle of the offending byte's last SCLK fall.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam logic [6:0] EXT_LAST  = 7'h0E;
  localparam logic [6:0] CTRL_ADDR = 7'h0F;
  localparam logic [6:0] STAT_ADDR = 7'h10;
  localparam logic [6:0] TRK_ADDR  = 7'h11;
  localparam logic [6:0] RAM_FIRST = 7'h20;
  localparam int unsigned WP_BIT   = 6;
  localparam logic [7:0] CTRL_MASK = 8'hC7;
  localparam logic [7:0] STAT_MASK = 8'h03;

  typedef enum logic [2:0] {
    RG_EXT, RG_CTRL, RG_STAT, RG_TRK, RG_RAM, RG_NONE
  } region_e;

  function automatic region_e decode(input logic [6:0] a);
    if (a <= EXT_LAST)       return RG_EXT;
    else if (a == CTRL_ADDR) return RG_CTRL;
    else if (a == STAT_ADDR) return RG_STAT;
    else if (a == TRK_ADDR)  return RG_TRK;
    else if (a >= RAM_FIRST) return RG_RAM;
    else                     return RG_NONE;
  endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/rtc_spi_engine.sv
module rtc_spi_engine #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_byte,
  output logic          rd_req,
  output logic          wr_req,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] wr_byte,
  output logic          tx_bit
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          sclk_d, in_data, wr_mode;
  logic [CW-1:0] bitcnt;
  logic [DW-2:0] rx;
  logic [DW-1:0] tx;
  logic [AW-1:0] addr;
  logic          rise, fall, byte_end;

  assign rise     = cs_s & sclk_s & ~sclk_d;
  assign fall     = cs_s & ~sclk_s & sclk_d;
  assign byte_end = fall & (bitcnt == LAST_BIT);
  assign wr_byte  = {rx, mosi_s};
  assign rd_req   = rise & (bitcnt == '0) & in_data & ~wr_mode;
  assign wr_req   = byte_end & in_data & wr_mode;
  assign cur_addr = addr;
  assign tx_bit   = tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      in_data <= 1'b0;
      wr_mode <= 1'b0;
      bitcnt  <= '0;
      rx      <= '0;
      tx      <= '0;
      addr    <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (!cs_s) begin
        bitcnt  <= '0;
        in_data <= 1'b0;
        tx      <= '0;
      end else begin
        if (rise) begin
          if (rd_req) tx <= rd_byte;
          else        tx <= {tx[DW-2:0], 1'b0};
        end
        if (fall) begin
          rx     <= {rx[DW-3:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
          if (byte_end) begin
            if (!in_data) begin
              addr    <= wr_byte[AW-1:0];
              wr_mode <= wr_byte[DW-1];
              in_data <= 1'b1;
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_spi_regmap.sv
module rtc_spi_regmap
  import rtc_spi_pkg::*;
#(
  parameter logic [7:0] CTRL_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] addr,
  input  logic       rd_req,
  input  logic       wr_req,
  input  logic [7:0] wdata,
  input  logic [7:0] ext_rdata,
  output logic [7:0] rdata,
  output logic       ext_rd,
  output logic       ext_wr,
  output logic [6:0] ext_addr,
  output logic [7:0] ext_wdata,
  output logic [7:0] ctrl_q,
  output logic [7:0] trickle_q
);
  localparam int unsigned RAM_DEPTH = 128 - int'(RAM_FIRST);
  localparam int unsigned RIW = $clog2(RAM_DEPTH);

  region_e        region;
  logic           wr_ok, is_ext;
  logic [6:0]     ram_off;
  logic [RIW-1:0] ram_idx;
  logic [7:0]     ram [RAM_DEPTH];

  assign region    = decode(addr);
  assign is_ext    = (region == RG_EXT) || (region == RG_STAT);
  assign wr_ok     = wr_req & ((region == RG_CTRL) | ~ctrl_q[WP_BIT]);
  assign ext_wr    = wr_ok & is_ext;
  assign ext_rd    = rd_req & is_ext;
  assign ext_addr  = addr;
  assign ext_wdata = wdata;
  assign ram_off   = addr - RAM_FIRST;
  assign ram_idx   = ram_off[RIW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST & CTRL_MASK;
      trickle_q <= '0;
    end else if (wr_ok) begin
      if (region == RG_CTRL) ctrl_q    <= wdata & CTRL_MASK;
      if (region == RG_TRK)  trickle_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && region == RG_RAM) ram[ram_idx] <= wdata;
  end

  always_comb begin
    case (region)
      RG_EXT:  rdata = ext_rdata;
      RG_STAT: rdata = ext_rdata & STAT_MASK;
      RG_CTRL: rdata = ctrl_q;
      RG_TRK:  rdata = trickle_q;
      RG_RAM:  rdata = ram[ram_idx];
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_spi_if.sv
module rtc_spi_if #(
  parameter logic [7:0]  CTRL_RST    = 8'h00,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       ext_rd,
  output logic       ext_wr,
  output logic [6:0] ext_addr,
  output logic [7:0] ext_wdata,
  input  logic [7:0] ext_rdata,
  output logic [7:0] ctrl_q,
  output logic [7:0] trickle_q
);
  logic [2:0] pins_s;
  logic       rd_req, wr_req, tx_bit;
  logic [6:0] cur_addr;
  logic [7:0] wr_byte, rd_byte;

  rtc_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs, spi_sclk, spi_mosi}), .q(pins_s)
  );

  rtc_spi_engine #(.AW(7), .DW(8)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .rd_byte(rd_byte), .rd_req(rd_req), .wr_req(wr_req),
    .cur_addr(cur_addr), .wr_byte(wr_byte), .tx_bit(tx_bit)
  );

  rtc_spi_regmap #(.CTRL_RST(CTRL_RST)) u_map (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr),
    .rd_req(rd_req), .wr_req(wr_req), .wdata(wr_byte),
    .ext_rdata(ext_rdata), .rdata(rd_byte),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ctrl_q(ctrl_q), .trickle_q(trickle_q)
  );

  assign spi_miso = pins_s[2] ? tx_bit : 1'bz;
endmodule

// File: rtl/rtc_spi_chk.sv
module rtc_spi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_rd,
  input logic       ext_wr,
  input logic [6:0] ext_addr,
  input logic [7:0] ctrl_q,
  input logic [7:0] trickle_q
);
  // R10
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |=> !ext_rd);

  // R10
  ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> (ext_addr <= 7'h0E || ext_addr == 7'h10));

  // R4
  wp_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> !ctrl_q[6]);

  // R4
  wp_trk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] |=> $stable(trickle_q));
endmodule

bind rtc_spi_if rtc_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rd(ext_rd), .ext_wr(ext_wr),
  .ext_addr(ext_addr), .ctrl_q(ctrl_q), .trickle_q(trickle_q)
);

// File: tb/tb_rtc_spi_if.sv
module tb_rtc_spi_if;
  localparam int HALF = 8;
  localparam int NV   = 14;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       spi_cs = 1'b0, spi_sclk = 1'b0, spi_mosi = 1'b0;
  wire        spi_miso;
  logic       ext_rd, ext_wr;
  logic [6:0] ext_addr;
  logic [7:0] ext_wdata, ext_rdata, ctrl_q, trickle_q;

  int tests = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_spi_if dut (
    .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ctrl_q(ctrl_q), .trickle_q(trickle_q)
  );

  // neighbour model: status returns all ones, others {1, addr}
  assign ext_rdata = (ext_addr == 7'h10) ? 8'hFF : {1'b1, ext_addr};

  always @(posedge clk) begin
    if (ext_wr) begin wr_cnt <= wr_cnt + 1; last_wa <= ext_addr; last_wd <= ext_wdata; end
    if (ext_rd) rd_cnt <= rd_cnt + 1;
  end

  // {write, addr, data, expected, requirement number}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 7'h11, 8'hA5, 8'h00, 4'd7},   // R7 write trickle
    {1'b0, 7'h11, 8'h00, 8'hA5, 4'd7},   // R7 read trickle, R1
    {1'b1, 7'h0F, 8'hFF, 8'h00, 4'd5},   // R5 control, sets protect
    {1'b0, 7'h0F, 8'h00, 8'hC7, 4'd5},   // R5 bits 5:3 read zero
    {1'b1, 7'h11, 8'h3C, 8'h00, 4'd4},   // R4 dropped
    {1'b0, 7'h11, 8'h00, 8'hA5, 4'd4},   // R4 unchanged
    {1'b1, 7'h0F, 8'h00, 8'h00, 4'd4},   // R4 control still writable
    {1'b1, 7'h25, 8'h77, 8'h00, 4'd8},   // R8 RAM
    {1'b0, 7'h25, 8'h00, 8'h77, 4'd8},   // R8
    {1'b1, 7'h7F, 8'h42, 8'h00, 4'd8},   // R8 top RAM byte
    {1'b0, 7'h7F, 8'h00, 8'h42, 4'd8},   // R8
    {1'b1, 7'h15, 8'h99, 8'h00, 4'd9},   // R9 unmapped write
    {1'b0, 7'h15, 8'h00, 8'h00, 4'd9},   // R9 reads zero
    {1'b0, 7'h10, 8'h00, 8'h03, 4'd6}    // R6 status masked
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i]; spi_sclk = 1'b1;
      tick(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic cs_on;  spi_cs = 1'b1; tick(4); endtask
  task automatic cs_off; tick(4); spi_cs = 1'b0; tick(6); endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_on; xfer({1'b1, a}, r); xfer(d, r); cs_off;
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_on; xfer({1'b0, a}, r); xfer(8'h00, d); cs_off;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    int c;
    tick(5); rst_n = 1'b1; tick(5);
    // R12 reset state
    check("R12 ctrl", ctrl_q, 8'h00);
    check("R12 trickle", trickle_q, 8'h00);
    tests++;
    if (spi_miso !== 1'bz) begin fails++; $display("FAIL R12 miso actual=%b expected=z", spi_miso); end

    for (int k = 0; k < NV; k++) begin
      logic [27:0] v;
      v = VEC[k];
      if (v[27]) wr1(v[26:20], v[19:12]);
      else begin
        rd1(v[26:20], r);
        check($sformatf("R%0d vec%0d", v[3:0], k), r, v[11:4]);
      end
    end

    // R2 burst write across wrap 0x7F -> 0x00, R10 write strobe
    c = wr_cnt;
    cs_on; xfer(8'hFE, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); cs_off;
    check("R2 wrap strobes", 8'(wr_cnt - c), 8'd1);
    check("R2 wrap addr", {1'b0, last_wa}, 8'h00);
    check("R10 wdata", last_wd, 8'h33);
    cs_on; xfer(8'h7E, r); xfer(8'h00, r); xfer(8'h00, r2); cs_off;
    check("R2 burst rd0", r, 8'h11);
    check("R2 burst rd1", r2, 8'h22);

    // R10 forwarded reads, one strobe per byte
    c = rd_cnt;
    cs_on; xfer(8'h05, r); xfer(8'h00, r); xfer(8'h00, r2); cs_off;
    check("R10 ext rd0", r, 8'h85);
    check("R10 ext rd1", r2, 8'h86);
    check("R10 rd strobes", 8'(rd_cnt - c), 8'd2);

    // R4 protect blocks forwarded write
    wr1(7'h0F, 8'h40);
    c = wr_cnt;
    wr1(7'h02, 8'h55);
    check("R4 no ext_wr", 8'(wr_cnt - c), 8'd0);
    wr1(7'h0F, 8'h00);
    check("R4 unprotect", ctrl_q, 8'h00);

    // R11 abort mid-byte
    cs_on; xfer(8'h91, r);
    for (int i = 0; i < 4; i++) begin
      spi_mosi = 1'b1; spi_sclk = 1'b1; tick(HALF); spi_sclk = 1'b0; tick(HALF);
    end
    cs_off;
    check("R11 trickle kept", trickle_q, 8'hA5);
    rd1(7'h11, r);
    check("R11 next period", r, 8'hA5);
    // R3 MISO released after deselect
    tests++;
    if (spi_miso !== 1'bz) begin fails++; $display("FAIL R3 miso actual=%b expected=z", spi_miso); end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule